// File: doc/BRIEF.md
# Paged Memory Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a single physical store that holds flash pages first and RAM pages after them. The 64 KiB logical space is cut into four 16 KiB windows, and each window is pointed at a physical page. The pointers come from bank registers that the CPU programs through I/O ports. Every memory cycle yields a physical page number and an in-page offset. The block also says whether the page is RAM, and passes a write strobe only when the target page can be written.

A mode input picks between two ways of filling the upper three windows. In the paired mode, one bank register drives two adjacent windows with an even/odd page pair. After reset, window 0 shows a fixed boot page. The first instruction fetch from the code window that follows it releases window 0 to flash page 0 for good.

Top module: `bank_mapper`

## Requirements
- R1: Address bits [15:14] choose the window, and `page_offset` equals `cpu_addr[13:0]` in every cycle.
- R2: A bank value with low byte `lo` and high byte `hi` decodes as follows. When `lo[7]` is 1 it names RAM page `FLASH_PAGES + lo[6:0]`. When `lo[7]` is 0 it names flash page `{hi & HI_MASK, lo[6:0]}`. With the defaults `FLASH_PAGES`=256 and `HI_MASK`=0x01.
- R3: An I/O write to port 0x05 stores the data with bit 7 set. An I/O read of port 0x05 returns the stored byte with bit 7 cleared.
- R4: Ports 0x06 and 0x07 hold the low bytes of bank A and bank B. Ports 0x0E and 0x0F hold their high bytes. Each of these ports reads back what was written to it. A read of any other port, and `io_rdata` whenever `io_rd` is low, gives 0xFF.
- R5: With `mode`=0, window 1 shows bank A, window 2 shows bank B, and window 3 shows the port-0x05 RAM bank.
- R6: With `mode`=1, window 1 shows bank A's page with bit 0 cleared, window 2 shows it with bit 0 set, and window 3 shows bank B.
- R7: After reset, window 0 shows `BOOT_PAGE` (default 255). A fetch (`fetch`=1) whose `pc` is at least 0x4000 and below 0x8000 ends boot. With `mode`=1 the upper limit is 0xC000 instead. From the next cycle on, window 0 shows page 0, and it keeps doing so until the next reset.
- R8: `ram_sel` is 1 exactly when the mapped page is at least `FLASH_PAGES`. `mem_wr_gated` equals `mem_wr` on such pages and is 0 on flash pages.
- R9: Reset clears every bank register to zero and enters boot.
- R10: A bank register write is visible in the mapping one clock after the write. A change of `mode` is visible in the same cycle. No wait states are inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Window mapping mode (0 single, 1 paired) |
| cpu_addr | input | 16 | CPU memory address |
| pc | input | 16 | Program counter of the current fetch |
| fetch | input | 1 | Current cycle is an instruction fetch |
| mem_wr | input | 1 | CPU memory write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| phys_page | output | PW (9) | Physical page index |
| page_offset | output | 14 | Offset within the page |
| ram_sel | output | 1 | Mapped page is RAM |
| mem_wr_gated | output | 1 | Write strobe passed to the store |

## Verification
Every value 0..255 is written to bank A and to bank B low bytes, in both modes and with both high-byte settings. This separates the RAM-flag path, the flash path and the high-bit merge, and it shows the even/odd pairing in the paired mode. The eight RAM bank values and a stray large value go through port 0x05, which shows bit 7 being forced on write and stripped on read. Fetches just inside and just outside the boot window, in both modes, tell the window edges apart. Writes held high on every access separate flash pages from RAM pages at the write gate.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int          FLASH_PAGES = 256,
  parameter int          RAM_SPAN    = 128,
  parameter logic [7:0]  HI_MASK     = 8'h01,
  parameter int          BOOT_PAGE   = 255,
  localparam int         PW          = $clog2(FLASH_PAGES + RAM_SPAN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic [15:0]   cpu_addr,
  input  logic [15:0]   pc,
  input  logic          fetch,
  input  logic          mem_wr,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [7:0]    io_port,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic [PW-1:0] phys_page,
  output logic [13:0]   page_offset,
  output logic          ram_sel,
  output logic          mem_wr_gated
);
  localparam logic [PW-1:0] FLASH_LIM = PW'(FLASH_PAGES);
  localparam logic [PW-1:0] BOOT_PG   = PW'(BOOT_PAGE);

  logic [7:0] a_lo, a_hi, b_lo, b_hi, r_lo;
  logic       boot;

  function automatic logic [PW-1:0] decode(input logic [7:0] lo, input logic [7:0] hi);
    logic [PW+7:0] w;
    if (lo[7]) w = (PW+8)'(FLASH_PAGES) + (PW+8)'(lo[6:0]);
    else       w = (PW+8)'({hi & HI_MASK, lo[6:0]});
    return w[PW-1:0];
  endfunction

  logic [PW-1:0] pg_a, pg_b, pg_r;
  assign pg_a = decode(a_lo, a_hi);
  assign pg_b = decode(b_lo, b_hi);
  assign pg_r = decode(r_lo, 8'h00);

  logic [15:0] win_top;
  logic        boot_exit;
  assign win_top   = mode ? 16'hC000 : 16'h8000;
  assign boot_exit = boot && fetch && pc >= 16'h4000 && pc < win_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_lo <= '0; a_hi <= '0; b_lo <= '0; b_hi <= '0; r_lo <= '0;
      boot <= 1'b1;
    end else begin
      if (io_wr) begin
        case (io_port)
          8'h05: r_lo <= io_wdata | 8'h80;
          8'h06: a_lo <= io_wdata;
          8'h07: b_lo <= io_wdata;
          8'h0E: a_hi <= io_wdata;
          8'h0F: b_hi <= io_wdata;
          default: ;
        endcase
      end
      if (boot_exit) boot <= 1'b0;
    end
  end

  always_comb begin
    case (cpu_addr[15:14])
      2'd0:    phys_page = boot ? BOOT_PG : '0;
      2'd1:    phys_page = mode ? {pg_a[PW-1:1], 1'b0} : pg_a;
      2'd2:    phys_page = mode ? {pg_a[PW-1:1], 1'b1} : pg_b;
      default: phys_page = mode ? pg_b : pg_r;
    endcase
  end

  assign page_offset  = cpu_addr[13:0];
  assign ram_sel      = phys_page >= FLASH_LIM;
  assign mem_wr_gated = mem_wr && ram_sel;

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd) begin
      case (io_port)
        8'h05: io_rdata = {1'b0, r_lo[6:0]};
        8'h06: io_rdata = a_lo;
        8'h07: io_rdata = b_lo;
        8'h0E: io_rdata = a_hi;
        8'h0F: io_rdata = b_hi;
        default: io_rdata = 8'hFF;
      endcase
    end
  end
endmodule

module bank_mapper_chk #(
  parameter int PW = 9,
  parameter int FLASH_PAGES = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode,
  input logic [15:0]   cpu_addr,
  input logic          io_rd,
  input logic          io_wr,
  input logic [7:0]    io_port,
  input logic [7:0]    io_rdata,
  input logic [PW-1:0] phys_page,
  input logic          ram_sel,
  input logic          mem_wr,
  input logic          mem_wr_gated,
  input logic          boot,
  input logic [7:0]    r_lo
);
  a_r3_port5_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_port == 8'h05) |-> !io_rdata[7]);

  a_r3_port5_store_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == 8'h05) |=> r_lo[7]);

  a_r4_unused_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !(io_port inside {8'h05, 8'h06, 8'h07, 8'h0E, 8'h0F})) |-> io_rdata == 8'hFF);

  a_r6_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && cpu_addr[15:14] == 2'd1) |-> !phys_page[0]);

  a_r6_pair_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && cpu_addr[15:14] == 2'd2) |-> phys_page[0]);

  a_r7_boot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !boot |=> !boot);

  a_r8_flash_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_page < PW'(FLASH_PAGES)) |-> !mem_wr_gated);

  a_r8_ram_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel && mem_wr) |-> mem_wr_gated);
endmodule

bind bank_mapper bank_mapper_chk #(.PW(PW), .FLASH_PAGES(FLASH_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .cpu_addr(cpu_addr),
  .io_rd(io_rd), .io_wr(io_wr), .io_port(io_port), .io_rdata(io_rdata),
  .phys_page(phys_page), .ram_sel(ram_sel), .mem_wr(mem_wr),
  .mem_wr_gated(mem_wr_gated), .boot(boot), .r_lo(r_lo)
);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic        clk = 0, rst_n = 0, mode = 0, fetch = 0, mem_wr = 0;
  logic        io_rd = 0, io_wr = 0;
  logic [15:0] cpu_addr = 0, pc = 0;
  logic [7:0]  io_port = 0, io_wdata = 0, io_rdata;
  logic [8:0]  phys_page;
  logic [13:0] page_offset;
  logic        ram_sel, mem_wr_gated;

  always #4 clk = ~clk;

  bank_mapper uut (.*);

  int total = 0, bad = 0;
  int m_alo, m_ahi, m_blo, m_bhi, m_r, m_boot;
  bit done = 0;

  function automatic int dec(int lo, int hi);
    if (lo >= 128) return 256 + lo - 128;
    return (lo % 128) + 128 * (hi % 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (addr=%h mode=%0d port=%h)",
               req, act, exp, cpu_addr, mode, io_port);
    end
  endtask

  task automatic idle();
    fetch = 0; mem_wr = 1; io_rd = 0; io_wr = 0; io_port = 8'h00; io_wdata = 0; pc = 0;
  endtask

  task automatic step();
    int slot, ep, er;
    string tag;
    #2;
    slot = cpu_addr / 16384;
    case (slot)
      0: begin ep = m_boot ? 255 : 0; tag = "R7"; end
      1: begin ep = mode ? (dec(m_alo, m_ahi) / 2) * 2 : dec(m_alo, m_ahi); tag = mode ? "R6" : "R5"; end
      2: begin ep = mode ? (dec(m_alo, m_ahi) / 2) * 2 + 1 : dec(m_blo, m_bhi); tag = mode ? "R6" : "R5"; end
      default: begin ep = mode ? dec(m_blo, m_bhi) : dec(m_r, 0); tag = mode ? "R6" : "R5"; end
    endcase
    chk({tag, "/R2 page"}, phys_page, ep);
    chk("R1 offset", page_offset, cpu_addr % 16384);
    chk("R8 ram_sel", ram_sel, ep >= 256);
    chk("R8 write gate", mem_wr_gated, (ep >= 256) && mem_wr);
    er = 255;
    if (io_rd) case (io_port)
      8'h05: er = m_r % 128;
      8'h06: er = m_alo;
      8'h07: er = m_blo;
      8'h0E: er = m_ahi;
      8'h0F: er = m_bhi;
      default: er = 255;
    endcase
    chk((io_port == 8'h05) ? "R3 port read" : "R4 port read", io_rdata, er);
    @(posedge clk);
    if (!rst_n) begin
      m_alo = 0; m_ahi = 0; m_blo = 0; m_bhi = 0; m_r = 0; m_boot = 1;
    end else begin
      if (io_wr) case (io_port)
        8'h05: m_r = io_wdata | 128;
        8'h06: m_alo = io_wdata;
        8'h07: m_blo = io_wdata;
        8'h0E: m_ahi = io_wdata;
        8'h0F: m_bhi = io_wdata;
        default: ;
      endcase
      if (m_boot && fetch && pc >= 16'h4000 && pc < (mode ? 17'h0C000 : 17'h08000)) m_boot = 0;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; idle(); step(); step(); rst_n = 1;
  endtask

  task automatic io_write(logic [7:0] p, logic [7:0] d);
    idle(); io_wr = 1; io_port = p; io_wdata = d; step();
  endtask

  task automatic io_read(logic [7:0] p);
    idle(); io_rd = 1; io_port = p; step();
  endtask

  task automatic access(logic [15:0] a);
    idle(); cpu_addr = a; step();
  endtask

  task automatic boot_fetch(logic [15:0] p);
    idle(); fetch = 1; pc = p; cpu_addr = p; step(); access(16'h0100);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_alo = 0; m_ahi = 0; m_blo = 0; m_bhi = 0; m_r = 0; m_boot = 1;
    @(negedge clk);
    do_reset();
    // R9 reset state
    access(16'h0000); access(16'h4000); access(16'hC123);
    io_read(8'h05); io_read(8'h06); io_read(8'h07); io_read(8'h0E); io_read(8'h0F);
    io_read(8'h42);
    // R7 boot window, mode 0
    mode = 0;
    boot_fetch(16'h3FFF); boot_fetch(16'h8000); boot_fetch(16'h9000);
    boot_fetch(16'h7FFF); boot_fetch(16'h0010);
    // R7 boot window, mode 1
    do_reset(); mode = 1;
    boot_fetch(16'hC000); boot_fetch(16'h3FFF); boot_fetch(16'hBFFF);
    boot_fetch(16'h0000);
    do_reset(); mode = 0;
    boot_fetch(16'h4000);
    // R3 RAM bank, mode 0
    for (int v = 0; v < 8; v++) begin
      io_write(8'h05, v[7:0]); access(16'hC000 + 16'(v)); io_read(8'h05);
    end
    io_write(8'h05, 8'h23); access(16'hFFFF); io_read(8'h05);
    io_write(8'h05, 8'hFF); access(16'hC010); io_read(8'h05);
    // R2 R4 R5 R6 sweeps
    for (int m = 0; m < 2; m++) begin
      for (int h = 0; h < 2; h++) begin
        mode = m[0];
        io_write(8'h0E, h[0] ? 8'hFF : 8'h00);
        io_write(8'h0F, h[0] ? 8'h81 : 8'h00);
        io_read(8'h0E); io_read(8'h0F);
        for (int v = 0; v < 256; v++) begin
          io_write(8'h06, v[7:0]);
          io_write(8'h07, 8'(255 - v));
          access(16'h4000 + 16'(v)); access(16'h8000 + 16'(v));
          access(16'hC000 + 16'(v)); io_read(8'h06); io_read(8'h07);
        end
      end
    end
    // R10 mode flip visible in the same cycle
    io_write(8'h06, 8'h85); io_write(8'h07, 8'h10); io_write(8'h05, 8'h03);
    mode = 0; access(16'hC000); mode = 1; access(16'hC000); access(16'h8000);
    mode = 0; access(16'h8000);
    io_read(8'h10); io_read(8'hFF);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule